// File: doc/BRIEF.md
# Decimal Shift-and-Round Corrector

This block is the last arithmetic step of an injection-rounded decimal adder. Upstream logic adds the rounding injection for the selected mode into the three digits below the kept significand, then adds the operands. This block receives that BCD sum: an overflow ("lead") digit, P kept digits and the guard, round and sticky digits. If the lead digit is zero, rounding is already complete and the block only truncates. If the lead digit is nonzero, the injection sits one digit too low. The block then shifts right by one digit, adds a mode-dependent correction into the new guard, round and sticky digits, and truncates.

The carry out of the correction reaches the kept digits through a run-of-nines flag vector, with no second ripple add. If that carry overflows the top kept digit, a second one-digit shift follows. The block also does the even-digit fix-up for ties-to-even and reports whether any discarded digit was nonzero. The result is registered, with a latency of one cycle.

Top module: `dec_round_fixup`

## Requirements
- R1: After reset `out_valid` is 0 and the outputs are zero. `out_valid` is `in_valid` delayed by one cycle, and the result of an accepted input appears on the outputs in that cycle.
- R2: If `lead_i` is 0, `sig_o` equals the kept digits of `sum_i` (digit k at bits [4k+3:4k]; digits 0, 1, 2 are sticky, round and guard; digits 3..P+2 are kept) and `exp_o` equals `exp_i`.
- R3: If `lead_i` is nonzero, the result is formed from `lead_i` followed by the upper P-1 kept digits. Kept digit 3 becomes the new guard digit. The correction is added at the new guard, round and sticky positions, and `exp_o` is `exp_i`+1 (or +2 under R6).
- R4: The mode codes are 0 toward zero, 1 ties away, 2 ties toward zero, 3 ties even, 4 toward +inf, 5 toward -inf, 6 away from zero (7 acts as 0). The correction (G,R,S) is (4,5,0) for codes 1-3. It is (9,0,0) for code 6, for code 4 with `neg_i`=0, and for code 5 with `neg_i`=1. It is (0,0,0) otherwise.
- R5: A carry out of the corrected low digits increments the kept digits, so a run of trailing nines rolls over to zeros.
- R6: If that increment overflows the top kept digit, the significand becomes 1 followed by zeros and `exp_o` is `exp_i`+2.
- R7: In mode 3, when the discarded part was exactly one half, the least significant result digit is even.
- R8: `inexact_o` is 1 exactly when the discarded digits were nonzero before injection. The upstream injection into (G,R,S) is assumed to be (5,0,0) for modes 1 and 3, (4,9,9) for mode 2, (9,9,9) for the away-from-zero cases of R4, and (0,0,0) otherwise.
- R9: Every digit of `sig_o` is a valid BCD digit (0-9) whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sum is valid this cycle |
| lead_i | input | 4 | Overflow digit above the kept digits |
| sum_i | input | 4*(P+3) | Kept digits plus guard, round, sticky (BCD) |
| mode_i | input | 3 | Rounding mode code |
| neg_i | input | 1 | Result sign, 1 = negative |
| exp_i | input | EW | Intermediate exponent |
| out_valid | output | 1 | Result valid |
| sig_o | output | 4*P | Rounded significand (BCD) |
| exp_o | output | EW | Final exponent |
| inexact_o | output | 1 | A nonzero digit was discarded |

## Verification
The bench builds the block with P=4 and EW=8. With these values every pre-injection sum fits in a 64-bit integer, so the expected result comes from plain integer division and mode rules applied to the value before injection. The small width also makes all-nines significands, the double shift and exact ties easy to hit. It applies every mode with both signs in the shifted and unshifted frames, plus a pseudo-random sweep.

// File: rtl/drf_pkg.sv
// Package: shared digit constants and rounding-mode helpers for the
// shift-and-round corrector. Assumes BCD digits of 4 bits.
package drf_pkg;

    localparam int DW = 4;

    typedef enum logic [2:0] {
        RM_TRUNC     = 3'd0,
        RM_HALF_AWAY = 3'd1,
        RM_HALF_ZERO = 3'd2,
        RM_HALF_EVEN = 3'd3,
        RM_CEIL      = 3'd4,
        RM_FLOOR     = 3'd5,
        RM_AWAY      = 3'd6
    } rmode_e;

    // Widen one BCD digit for small decimal arithmetic.
    function automatic logic [13:0] dval(input logic [3:0] d);
        return {10'd0, d};
    endfunction

    // True when the mode rounds the magnitude upward for this sign.
    function automatic logic away_dir(input logic [2:0] m, input logic neg);
        return (m == RM_AWAY) || (m == RM_CEIL && !neg) || (m == RM_FLOOR && neg);
    endfunction

    // True for the three ties modes.
    function automatic logic is_ties(input logic [2:0] m);
        return (m == RM_HALF_AWAY) || (m == RM_HALF_ZERO) || (m == RM_HALF_EVEN);
    endfunction

    // Correction added at the shifted guard/round/sticky digits, as a value.
    function automatic logic [13:0] corr_val(input logic [2:0] m, input logic neg);
        if (is_ties(m))        return 14'd450;
        else if (away_dir(m, neg)) return 14'd900;
        else                   return 14'd0;
    endfunction

    // Injection assumed to have been added upstream at guard/round/sticky.
    function automatic logic [13:0] inj_val(input logic [2:0] m, input logic neg);
        if (m == RM_HALF_AWAY || m == RM_HALF_EVEN) return 14'd500;
        else if (m == RM_HALF_ZERO)                 return 14'd499;
        else if (away_dir(m, neg))                  return 14'd999;
        else                                        return 14'd0;
    endfunction

endpackage

// File: rtl/drf_align.sv
// Module: picks the frame (shifted or not), forms the kept digits, adds the
// correction into the low digits and derives carry, exact-tie and inexact.
// Assumes sum_i already carries the upstream injection listed in inj_val.
module drf_align
    import drf_pkg::*;
#(
    parameter int P = 16
) (
    input  logic [3:0]          lead_i,
    input  logic [(P+3)*DW-1:0] sum_i,
    input  logic [2:0]          mode_i,
    input  logic                neg_i,
    output logic                shifted_o,
    output logic [P*DW-1:0]     keep_o,
    output logic                carry_o,
    output logic                tie_o,
    output logic                inexact_o
);

    localparam int SW = (P+3)*DW;

    logic [3:0]  d0, d1, d2, d3;
    logic [13:0] low_unsh, low_sh, low4_sh, corr, inj, tot;
    logic        rem_zero;

    // Split the low digits and choose the frame.
    always_comb begin
        d0        = sum_i[3:0];
        d1        = sum_i[7:4];
        d2        = sum_i[11:8];
        d3        = sum_i[15:12];
        shifted_o = (lead_i != 4'd0);
        keep_o    = shifted_o ? {lead_i, sum_i[SW-1:16]} : sum_i[SW-1:12];
    end

    // Correct the discarded digits and derive carry, tie and inexact.
    always_comb begin
        low_unsh  = dval(d2) * 14'd100 + dval(d1) * 14'd10 + dval(d0);
        low_sh    = dval(d3) * 14'd100 + dval(d2) * 14'd10 + dval(d1);
        low4_sh   = dval(d3) * 14'd1000 + low_unsh;
        corr      = shifted_o ? corr_val(mode_i, neg_i) : 14'd0;
        inj       = inj_val(mode_i, neg_i);
        tot       = (shifted_o ? low_sh : low_unsh) + corr;
        carry_o   = (tot >= 14'd1000);
        rem_zero  = (tot == 14'd0) || (tot == 14'd1000);
        inexact_o = shifted_o ? (low4_sh != inj) : (low_unsh != inj);
        tie_o     = (mode_i == RM_HALF_EVEN) && rem_zero && (!shifted_o || d0 == 4'd0);
    end

    // An exact tie always discards a nonzero half.
    always_comb begin
        p_tie_inexact_r7: assert (!tie_o || inexact_o);
    end

    // Without a shift no correction is added, so no carry can arise.
    always_comb begin
        p_no_carry_unshifted_r2: assert (shifted_o || !carry_o);
    end

endmodule

// File: rtl/drf_incr.sv
// Module: adds the correction carry into the kept digits using a
// run-of-nines flag vector, applies the ties-to-even fix-up and performs the
// second one-digit shift on overflow. Assumes BCD kept digits.
module drf_incr
    import drf_pkg::*;
#(
    parameter int P = 16
) (
    input  logic [P*DW-1:0] keep_i,
    input  logic            inc_i,
    input  logic            even_i,
    output logic [P*DW-1:0] keep_o,
    output logic            wrap_o
);

    logic [P:0]      nine_run;
    logic [P*DW-1:0] bumped;

    assign nine_run[0] = 1'b1;

    for (genvar k = 0; k < P; k++) begin : g_dig
        logic [3:0] dk;
        assign dk            = keep_i[k*DW +: DW];
        assign nine_run[k+1] = nine_run[k] && (dk == 4'd9);
        // Digit k moves only when every lower kept digit is nine.
        assign bumped[k*DW +: DW] = (inc_i && nine_run[k]) ?
                                    ((dk == 4'd9) ? 4'd0 : dk + 4'd1) : dk;
    end

    // Overflow shift or even fix-up on the incremented digits.
    always_comb begin
        wrap_o = inc_i && nine_run[P];
        keep_o = bumped;
        if (wrap_o)
            keep_o = {4'd1, {(P-1)*DW{1'b0}}};
        else if (even_i)
            keep_o[0] = 1'b0;
    end

    // Overflow only from an all-nines significand.
    always_comb begin
        p_wrap_allnine_r6: assert (!wrap_o || keep_i == {P{4'd9}});
    end

endmodule

// File: rtl/dec_round_fixup.sv
// Module: top of the shift-and-round corrector. Registers the rounded
// significand, final exponent and inexact flag one cycle after in_valid.
// Assumes a BCD sum with the mode's injection already added (see drf_pkg).
module dec_round_fixup
    import drf_pkg::*;
#(
    parameter int P  = 16,
    parameter int EW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          lead_i,
    input  logic [(P+3)*DW-1:0] sum_i,
    input  logic [2:0]          mode_i,
    input  logic                neg_i,
    input  logic [EW-1:0]       exp_i,
    output logic                out_valid,
    output logic [P*DW-1:0]     sig_o,
    output logic [EW-1:0]       exp_o,
    output logic                inexact_o
);

    logic            shifted, carry, tie, inexact, wrap;
    logic [P*DW-1:0] keep, keep_fin;
    logic [EW-1:0]   exp_nx;

    drf_align #(.P(P)) u_align (
        .lead_i   (lead_i),
        .sum_i    (sum_i),
        .mode_i   (mode_i),
        .neg_i    (neg_i),
        .shifted_o(shifted),
        .keep_o   (keep),
        .carry_o  (carry),
        .tie_o    (tie),
        .inexact_o(inexact)
    );

    drf_incr #(.P(P)) u_incr (
        .keep_i(keep),
        .inc_i (carry),
        .even_i(tie),
        .keep_o(keep_fin),
        .wrap_o(wrap)
    );

    // Exponent grows by one per digit shifted out.
    assign exp_nx = exp_i + EW'(shifted) + EW'(wrap);

    // Output register, loaded on each accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sig_o     <= '0;
            exp_o     <= '0;
            inexact_o <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sig_o     <= keep_fin;
                exp_o     <= exp_nx;
                inexact_o <= inexact;
            end
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_exp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lead_i == 4'd0) |=> (exp_o == $past(exp_i)));

    p_exp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lead_i != 4'd0) |=>
            (exp_o == EW'($past(exp_i) + EW'(1)) || exp_o == EW'($past(exp_i) + EW'(2))));

    for (genvar k = 0; k < P; k++) begin : g_bcd_chk
        p_bcd_digit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (sig_o[k*DW +: DW] <= 4'd9));
    end

endmodule

// File: tb/dec_round_fixup_tb.sv
module dec_round_fixup_tb;

    localparam int P  = 4;
    localparam int EW = 8;
    localparam int SW = (P+3)*4;
    localparam int E0 = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [3:0]      lead_i = '0;
    logic [SW-1:0]   sum_i = '0;
    logic [2:0]      mode_i = '0;
    logic            neg_i = 1'b0;
    logic [EW-1:0]   exp_i = '0;
    logic            out_valid;
    logic [P*4-1:0]  sig_o;
    logic [EW-1:0]   exp_o;
    logic            inexact_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    longint q_sig[$];
    int     q_exp[$];
    bit     q_inx[$];
    string  q_tag[$];

    always #10 clk = ~clk;   // 50 MHz

    dec_round_fixup #(.P(P), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lead_i(lead_i),
        .sum_i(sum_i), .mode_i(mode_i), .neg_i(neg_i), .exp_i(exp_i),
        .out_valid(out_valid), .sig_o(sig_o), .exp_o(exp_o), .inexact_o(inexact_o)
    );

    function automatic longint pw10(input int n);
        longint r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    function automatic bit up_dir(input int m, input bit neg);
        return (m == 6) || (m == 4 && !neg) || (m == 5 && neg);
    endfunction

    function automatic longint inj_of(input int m, input bit neg);
        if (m == 1 || m == 3) return 500;
        if (m == 2)           return 499;
        if (up_dir(m, neg))   return 999;
        return 0;
    endfunction

    function automatic logic [SW-1:0] to_bcd(input longint v);
        logic [SW-1:0] r = '0;
        longint t = v;
        for (int i = 0; i < P+3; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Driver: computes the expected result from the pre-injection value x.
    task automatic drive(input longint x, input int m, input bit neg, input string tag);
        longint post, unit, q, rem, half;
        bit s, up;
        int ex;
        post = x + inj_of(m, neg);
        s    = (post / pw10(P+3)) != 0;
        unit = s ? pw10(4) : pw10(3);
        q    = x / unit;
        rem  = x % unit;
        half = unit / 2;
        case (m)
            1: up = (rem >= half);
            2: up = (rem > half);
            3: up = (rem > half) || (rem == half && q[0]);
            default: up = up_dir(m, neg) && (rem != 0);
        endcase
        q  = q + longint'(up);
        ex = E0 + int'(s);
        if (q >= pw10(P)) begin
            q  = q / 10;
            ex = ex + 1;
        end
        q_sig.push_back(q);
        q_exp.push_back(ex);
        q_inx.push_back(rem != 0);
        q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1;
        lead_i   = 4'(post / pw10(P+3));
        sum_i    = to_bcd(post % pw10(P+3));
        mode_i   = 3'(m);
        neg_i    = neg;
        exp_i    = EW'(E0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a result is presented.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q_sig.size() == 0) begin
                fails++;
                $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
            end else begin
                longint es, as_v;
                int ee;
                bit ei, bad_bcd;
                string tg;
                es = q_sig.pop_front();
                ee = q_exp.pop_front();
                ei = q_inx.pop_front();
                tg = q_tag.pop_front();
                as_v = 0;
                bad_bcd = 0;
                for (int i = P-1; i >= 0; i--) begin
                    if (sig_o[i*4 +: 4] > 4'd9) bad_bcd = 1;   // R9
                    as_v = as_v * 10 + longint'(sig_o[i*4 +: 4]);
                end
                if (bad_bcd || as_v != es || int'(exp_o) != ee || inexact_o != ei) begin
                    fails++;
                    $display("FAIL %s: actual sig=%0d exp=%0d inx=%0b bcdbad=%0b expected sig=%0d exp=%0d inx=%0b",
                             tg, as_v, exp_o, inexact_o, bad_bcd, es, ee, ei);
                end
            end
        end
    end

    initial begin
        longint lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R1 reset state
        if (out_valid !== 1'b0 || sig_o !== '0 || exp_o !== '0 || inexact_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset state actual v=%0b sig=%0h expected v=0 sig=0", out_valid, sig_o);
        end

        // R2: unshifted truncation
        drive(64'd1234567, 0, 0, "R2");
        drive(64'd1234000, 0, 1, "R2");
        drive(64'd9876001, 5, 0, "R2");

        // R3/R4: shifted frame, every mode with both signs
        for (int m = 0; m < 7; m++) begin
            drive(64'd12345678, m, 0, "R4");
            drive(64'd12345678, m, 1, "R4");
            drive(64'd87654321, m, 1, "R3");
        end

        // R5: carry through trailing nines
        drive(64'd12999500, 1, 0, "R5");
        drive(64'd40999001, 6, 1, "R5");
        drive(64'd1999500, 3, 0, "R5");

        // R6: all-nines overflow to a second shift
        drive(64'd99999400, 1, 0, "R6");
        drive(64'd99990001, 6, 1, "R6");
        drive(64'd99990001, 4, 0, "R6");
        drive(64'd99990001, 5, 0, "R6");   // rounds down: no overflow

        // R7: ties to even, both frames
        drive(64'd1235500, 3, 0, "R7");
        drive(64'd1234500, 3, 1, "R7");
        drive(64'd1234501, 3, 0, "R7");
        drive(64'd12345000, 3, 0, "R7");
        drive(64'd12355000, 3, 1, "R7");
        drive(64'd12345001, 3, 0, "R7");
        // ties toward zero around the half point
        drive(64'd1234500, 2, 0, "R4");
        drive(64'd1234501, 2, 0, "R4");
        drive(64'd12345000, 2, 1, "R4");
        drive(64'd12345001, 2, 1, "R4");

        // R8: exact inputs in every mode and frame
        for (int m = 0; m < 7; m++) begin
            drive(64'd5678000, m, 1, "R8");
            drive(64'd56780000, m, 0, "R8");
        end

        // R3 sweep over values, modes and signs
        lcg = 64'd12345;
        for (int i = 0; i < 200; i++) begin
            lcg = (lcg * 64'd1103515245 + 64'd12345) % 64'd2147483648;
            drive(lcg % 64'd99998000, int'(lcg % 7), lcg[5], "R3");
        end

        repeat (3) @(negedge clk);
        checks++;   // R1: every expected result was produced
        if (q_sig.size() != 0) begin
            fails++;
            $display("FAIL R1: pending results actual %0d expected 0", q_sig.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1: watchdog expired actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule